// File: doc/BRIEF.md
# Sound Generator Control Hub

This block is the register and event hub of a five-voice sound generator. The voices are two pulse voices, a triangle voice, a noise voice and a sample-playback voice. The hub decodes single-byte CPU reads and writes. Each voice gets its own four-byte register window. The hub also owns a shared enable/status register and forwards a frame-control register to the external frame sequencer. The voices and the sequencer sit outside the block and connect only through ports.

The sequencer reports typed events: an envelope/linear pulse, a length/sweep pulse and an interrupt pulse. The hub turns each event into registered clock strobes for the voices that take part in it. It also holds a level-sensitive interrupt request toward the CPU. A unit tick input is fanned out as timer ticks to every voice.

CPU accesses are single-cycle and always accepted, so there is no back-pressure. Window strobes and the frame write strobe are combinational in the cycle of the access. Read data, enable bits, the illegal-access flag and all clock strobes are registered and appear one cycle later.

Top module: `audio_ctl_hub`

## Requirements
- R1: An access to 0x4000–0x4013 raises exactly one bit of `win_wr`/`win_rd` in the same cycle: bit 0 pulse 1 (0x4000–03), bit 1 pulse 2 (0x4004–07), bit 2 triangle (0x4008–0B), bit 3 noise (0x400C–0F), bit 4 sample voice (0x4010–13). `win_ofs` equals the address minus the window base. A read returns byte i of `win_rdata` (bits 8i+7..8i) on `bus_rdata` in the next cycle.
- R2: A write to 0x4015 loads `len_en[3:0]` (pulse 1, pulse 2, triangle, noise) from data bits 3:0 and `samp_en` from bit 4. The new values are visible the next cycle.
- R3: A read of 0x4015 returns `len_active` in bits 3:0, `samp_active` in bit 4 and `frm_irq_flag` in bit 6. Bits 5 and 7 are zero.
- R4: A write to 0x4017 raises `frm_wr` in the same cycle, with the byte on `frm_wdata`. If data bit 7 is set, `len_clk` is 4'b1111 in the next cycle.
- R5: A read of 0x4017 returns `frm_value` in the next cycle.
- R6: `ev_envlin` gives `env_clk` = 3'b111 (bits: pulse 1, pulse 2, noise) and `lin_clk` = 1 in the next cycle, with no length or sweep strobe.
- R7: `ev_lensweep` gives `len_clk` = 4'b1111 and `sweep_clk` = 2'b11 (pulse 1, pulse 2) in the next cycle, with no envelope or linear strobe.
- R8: `irq_req` rises the cycle after `ev_irq`. It stays high while `frm_irq_flag` is high and falls the cycle after the flag is low with no `ev_irq` present.
- R9: `unit_tick` gives `tmr_tick` = 4'b1111 (pulse 1, pulse 2, noise, sample) and `tri_ticks` = 2 in the next cycle. Both are zero otherwise.
- R10: An access to any address outside 0x4000–0x4013, 0x4015 and 0x4017 changes no enable, raises no strobe, reads as zero and pulses `bad_acc` for one cycle, in the cycle after the access.
- R11: While synchronous reset `rst` is high, all registered outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_addr | input | 16 | CPU byte address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data, registered |
| bad_acc | output | 1 | Illegal-access pulse |
| win_wr | output | 5 | Per-voice window write strobes |
| win_rd | output | 5 | Per-voice window read strobes |
| win_ofs | output | 2 | Offset within window |
| win_wdata | output | 8 | Write data to voices |
| win_rdata | input | 40 | Packed read bytes from voices |
| len_en | output | 4 | Length enables |
| samp_en | output | 1 | Sample voice enable |
| len_active | input | 4 | Length-active flags |
| samp_active | input | 1 | Sample voice active |
| frm_wr | output | 1 | Frame-control write strobe |
| frm_wdata | output | 8 | Frame-control byte |
| frm_value | input | 8 | Sequencer register value |
| frm_irq_flag | input | 1 | Sequencer IRQ flag |
| ev_envlin | input | 1 | Envelope/linear event |
| ev_lensweep | input | 1 | Length/sweep event |
| ev_irq | input | 1 | IRQ event |
| unit_tick | input | 1 | Unit tick |
| env_clk | output | 3 | Envelope strobes |
| lin_clk | output | 1 | Triangle linear strobe |
| len_clk | output | 4 | Length strobes |
| sweep_clk | output | 2 | Sweep strobes |
| tmr_tick | output | 4 | Timer ticks |
| tri_ticks | output | 2 | Triangle tick count |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench probes the window edges and the holes at 0x4014 and 0x4016. A decoder with an off-by-one bound would strobe a voice for those holes, or miss the last byte of the sample window. Writes to the frame register are sent with and without bit 7, so an immediate length clock that is missing or always present shows up in `len_clk`. Each event type is checked on its own. This catches a fan-out that clocks the sample voice, sweeps the triangle or leaks envelope strobes into the length group. The interrupt is held and then released through the flag, which exposes a pulse-only or a never-clearing request.

// File: rtl/audio_hub_pkg.sv
package audio_hub_pkg;
  typedef enum logic [1:0] {RG_WIN, RG_STAT, RG_FRAME, RG_NONE} region_e;
  typedef struct packed {
    region_e     region;
    logic [2:0]  win;
    logic [1:0]  ofs;
  } dec_t;
endpackage

// File: rtl/hub_decode.sv
module hub_decode
  import audio_hub_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE     = 'h4000,
  parameter int NUM_WIN  = 5,
  parameter int STAT_OFS = 'h15,
  parameter int FRM_OFS  = 'h17
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NUM_WIN * 4);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(BASE + STAT_OFS);
  localparam logic [ADDR_W-1:0] FRM_A  = ADDR_W'(BASE + FRM_OFS);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel        = addr - BASE_A;
    dec.win    = rel[4:2];
    dec.ofs    = rel[1:0];
    if (addr >= BASE_A && rel < SPAN) dec.region = RG_WIN;
    else if (addr == STAT_A)          dec.region = RG_STAT;
    else if (addr == FRM_A)           dec.region = RG_FRAME;
    else                              dec.region = RG_NONE;
  end
endmodule

// File: rtl/hub_events.sv
module hub_events #(
  parameter int NUM_LEN = 4,
  parameter int NUM_ENV = 3,
  parameter int NUM_SWP = 2,
  parameter int NUM_TMR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_envlin,
  input  logic               ev_lensweep,
  input  logic               imm_len,
  input  logic               unit_tick,
  output logic [NUM_ENV-1:0] env_clk,
  output logic               lin_clk,
  output logic [NUM_LEN-1:0] len_clk,
  output logic [NUM_SWP-1:0] sweep_clk,
  output logic [NUM_TMR-1:0] tmr_tick,
  output logic [1:0]         tri_ticks
);
  always_ff @(posedge clk) begin
    if (rst) begin
      env_clk   <= '0;
      lin_clk   <= 1'b0;
      len_clk   <= '0;
      sweep_clk <= '0;
      tmr_tick  <= '0;
      tri_ticks <= '0;
    end else begin
      env_clk   <= {NUM_ENV{ev_envlin}};
      lin_clk   <= ev_envlin;
      len_clk   <= {NUM_LEN{ev_lensweep | imm_len}};
      sweep_clk <= {NUM_SWP{ev_lensweep}};
      tmr_tick  <= {NUM_TMR{unit_tick}};
      tri_ticks <= unit_tick ? 2'd2 : 2'd0;
    end
  end
endmodule

// File: rtl/hub_irq.sv
module hub_irq (
  input  logic clk,
  input  logic rst,
  input  logic ev_irq,
  input  logic irq_flag,
  output logic irq_req
);
  always_ff @(posedge clk) begin
    if (rst)         irq_req <= 1'b0;
    else if (ev_irq) irq_req <= 1'b1;
    else if (!irq_flag) irq_req <= 1'b0;
  end
endmodule

// File: rtl/audio_ctl_hub.sv
module audio_ctl_hub
  import audio_hub_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_WIN = 5,
  parameter int NUM_LEN = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      bad_acc,
  output logic [NUM_WIN-1:0]        win_wr,
  output logic [NUM_WIN-1:0]        win_rd,
  output logic [1:0]                win_ofs,
  output logic [DATA_W-1:0]         win_wdata,
  input  logic [NUM_WIN*DATA_W-1:0] win_rdata,
  output logic [NUM_LEN-1:0]        len_en,
  output logic                      samp_en,
  input  logic [NUM_LEN-1:0]        len_active,
  input  logic                      samp_active,
  output logic                      frm_wr,
  output logic [DATA_W-1:0]         frm_wdata,
  input  logic [DATA_W-1:0]         frm_value,
  input  logic                      frm_irq_flag,
  input  logic                      ev_envlin,
  input  logic                      ev_lensweep,
  input  logic                      ev_irq,
  input  logic                      unit_tick,
  output logic [2:0]                env_clk,
  output logic                      lin_clk,
  output logic [NUM_LEN-1:0]        len_clk,
  output logic [1:0]                sweep_clk,
  output logic [3:0]                tmr_tick,
  output logic [1:0]                tri_ticks,
  output logic                      irq_req
);
  localparam int SLOTS = 8;

  dec_t              dec;
  logic [DATA_W-1:0] rd_arr [SLOTS];
  logic [DATA_W-1:0] stat_byte;
  logic [DATA_W-1:0] rd_sel;
  logic              imm_len;

  hub_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_rd
    if (i < NUM_WIN) begin : g_live
      assign rd_arr[i] = win_rdata[i*DATA_W +: DATA_W];
    end else begin : g_pad
      assign rd_arr[i] = '0;
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign win_wr[i] = bus_wr && dec.region == RG_WIN && dec.win == 3'(i);
    assign win_rd[i] = bus_rd && dec.region == RG_WIN && dec.win == 3'(i);
  end

  assign win_ofs   = dec.ofs;
  assign win_wdata = bus_wdata;
  assign frm_wr    = bus_wr && dec.region == RG_FRAME;
  assign frm_wdata = bus_wdata;
  assign imm_len   = frm_wr && bus_wdata[DATA_W-1];

  always_comb begin
    stat_byte = '0;
    stat_byte[NUM_LEN-1:0] = len_active;
    stat_byte[4] = samp_active;
    stat_byte[6] = frm_irq_flag;
    case (dec.region)
      RG_WIN:   rd_sel = rd_arr[dec.win];
      RG_STAT:  rd_sel = stat_byte;
      RG_FRAME: rd_sel = frm_value;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bad_acc   <= 1'b0;
      len_en    <= '0;
      samp_en   <= 1'b0;
    end else begin
      bad_acc <= (bus_wr || bus_rd) && dec.region == RG_NONE;
      if (bus_rd) bus_rdata <= rd_sel;
      if (bus_wr && dec.region == RG_STAT) begin
        len_en  <= bus_wdata[NUM_LEN-1:0];
        samp_en <= bus_wdata[4];
      end
    end
  end

  hub_events #(.NUM_LEN(NUM_LEN)) u_ev (
    .clk         (clk),
    .rst         (rst),
    .ev_envlin   (ev_envlin),
    .ev_lensweep (ev_lensweep),
    .imm_len     (imm_len),
    .unit_tick   (unit_tick),
    .env_clk     (env_clk),
    .lin_clk     (lin_clk),
    .len_clk     (len_clk),
    .sweep_clk   (sweep_clk),
    .tmr_tick    (tmr_tick),
    .tri_ticks   (tri_ticks)
  );

  hub_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .ev_irq   (ev_irq),
    .irq_flag (frm_irq_flag),
    .irq_req  (irq_req)
  );
endmodule

// File: rtl/audio_ctl_hub_chk.sv
module audio_ctl_hub_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic       bad_acc,
  input logic [4:0] win_wr,
  input logic [4:0] win_rd,
  input logic       frm_wr,
  input logic       frm_irq_flag,
  input logic       ev_envlin,
  input logic       ev_lensweep,
  input logic       ev_irq,
  input logic       unit_tick,
  input logic [2:0] env_clk,
  input logic [1:0] sweep_clk,
  input logic [3:0] len_clk,
  input logic [1:0] tri_ticks,
  input logic       irq_req
);
  // R1
  win_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_wr) && $onehot0(win_rd));
  // R4
  len_src_chk: assert property (@(posedge clk) disable iff (rst)
    (len_clk != 4'd0) |-> $past(ev_lensweep || (frm_wr && bus_wdata[7])));
  // R6
  env_src_chk: assert property (@(posedge clk) disable iff (rst)
    (env_clk != 3'd0) |-> $past(ev_envlin));
  // R7
  sweep_src_chk: assert property (@(posedge clk) disable iff (rst)
    (sweep_clk != 2'd0) |-> $past(ev_lensweep));
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_irq |=> irq_req);
  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_irq && !frm_irq_flag) |=> !irq_req);
  // R9
  tick_chk: assert property (@(posedge clk) disable iff (rst)
    unit_tick |=> (tri_ticks == 2'd2));
  // R10
  bad_src_chk: assert property (@(posedge clk) disable iff (rst)
    bad_acc |-> $past(bus_wr || bus_rd));
endmodule

bind audio_ctl_hub audio_ctl_hub_chk i_chk (.*);

// File: tb/test_audio_ctl_hub.sv
module test_audio_ctl_hub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        bad_acc;
  logic [4:0]  win_wr, win_rd;
  logic [1:0]  win_ofs;
  logic [7:0]  win_wdata;
  logic [39:0] win_rdata = '0;
  logic [3:0]  len_en;
  logic        samp_en;
  logic [3:0]  len_active = '0;
  logic        samp_active = 0;
  logic        frm_wr;
  logic [7:0]  frm_wdata;
  logic [7:0]  frm_value = '0;
  logic        frm_irq_flag = 0;
  logic        ev_envlin = 0, ev_lensweep = 0, ev_irq = 0, unit_tick = 0;
  logic [2:0]  env_clk;
  logic        lin_clk;
  logic [3:0]  len_clk;
  logic [1:0]  sweep_clk;
  logic [3:0]  tmr_tick;
  logic [1:0]  tri_ticks;
  logic        irq_req;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] m_en = '0;

  always #10 clk = ~clk;

  audio_ctl_hub i_audio_ctl_hub (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_win(logic [15:0] a);
    if (a >= 16'h4000 && a <= 16'h4013) return int'((a - 16'h4000) >> 2);
    return -1;
  endfunction

  function automatic bit is_legal(logic [15:0] a);
    return exp_win(a) >= 0 || a == 16'h4015 || a == 16'h4017;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    int w = exp_win(a);
    if (w >= 0) return win_rdata[w*8 +: 8];
    if (a == 16'h4015) return {1'b0, frm_irq_flag, 1'b0, samp_active, len_active};
    if (a == 16'h4017) return frm_value;
    return 8'h00;
  endfunction

  task automatic access(bit wr, bit rd, logic [15:0] a, logic [7:0] d);
    int w = exp_win(a);
    logic [4:0] ew = (w >= 0) ? 5'(1 << w) : 5'd0;
    logic [7:0] er;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #2;
    er = exp_read(a);
    chk("R1 win_wr", win_wr, wr ? ew : 5'd0);
    chk("R1 win_rd", win_rd, rd ? ew : 5'd0);
    if (w >= 0) chk("R1 ofs", win_ofs, a[1:0] - 2'd0);
    chk("R4 frm_wr", frm_wr, wr && a == 16'h4017);
    if (wr && a == 16'h4017) chk("R4 frm_wdata", frm_wdata, d);
    if (wr && a == 16'h4015) m_en = d[4:0];
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0;
    chk("R10 bad_acc", bad_acc, (wr || rd) && !is_legal(a));
    if (rd) chk("R1 R3 R5 R10 rdata", bus_rdata, er);
    chk("R2 enables", {samp_en, len_en}, m_en);
    chk("R4 len_clk", len_clk, (wr && a == 16'h4017 && d[7]) ? 4'hF : 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 reset", {bus_rdata, bad_acc, len_en, samp_en, env_clk, lin_clk,
                      len_clk, sweep_clk, tmr_tick, tri_ticks, irq_req}, '0);
    rst = 0;
    @(posedge clk); #1;

    win_rdata = 40'h55_44_33_22_11;
    len_active = 4'b1010; samp_active = 1; frm_irq_flag = 1; frm_value = 8'hA5;
    // directed window edges and holes (R1, R10)
    access(0, 1, 16'h4000, 0);
    access(0, 1, 16'h4013, 0);
    access(1, 1, 16'h4014, 8'hFF);
    access(1, 1, 16'h4016, 8'hFF);
    access(1, 0, 16'h3FFF, 8'hFF);
    // R2 R3 status write/read
    access(1, 0, 16'h4015, 8'hFF);
    access(1, 0, 16'h4015, 8'h15);
    access(0, 1, 16'h4015, 0);
    // R4 R5 frame writes with and without bit 7
    access(1, 0, 16'h4017, 8'h80);
    access(1, 0, 16'h4017, 8'h40);
    access(0, 1, 16'h4017, 0);

    // R6
    ev_envlin = 1; @(posedge clk); #1; ev_envlin = 0;
    chk("R6 env", {env_clk, lin_clk, len_clk, sweep_clk}, {3'b111, 1'b1, 4'h0, 2'b00});
    @(posedge clk); #1;
    chk("R6 env off", {env_clk, lin_clk}, 4'h0);
    // R7
    ev_lensweep = 1; @(posedge clk); #1; ev_lensweep = 0;
    chk("R7 lensweep", {env_clk, lin_clk, len_clk, sweep_clk}, {3'b000, 1'b0, 4'hF, 2'b11});
    // R9
    unit_tick = 1; @(posedge clk); #1; unit_tick = 0;
    chk("R9 tick", {tmr_tick, tri_ticks}, {4'hF, 2'd2});
    @(posedge clk); #1;
    chk("R9 tick off", {tmr_tick, tri_ticks}, 6'd0);
    // R8
    frm_irq_flag = 1; ev_irq = 1; @(posedge clk); #1; ev_irq = 0;
    chk("R8 irq set", irq_req, 1'b1);
    repeat (4) @(posedge clk); #1;
    chk("R8 irq held", irq_req, 1'b1);
    frm_irq_flag = 0; @(posedge clk); #1;
    chk("R8 irq clear", irq_req, 1'b0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a = 16'h3FFE + 16'($urandom_range(0, 27));
      win_rdata = {$urandom(), $urandom()};
      len_active = 4'($urandom); samp_active = 1'($urandom);
      frm_irq_flag = 1'($urandom); frm_value = 8'($urandom);
      access(1'($urandom), 1'($urandom), a, 8'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule